// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Global Mask

This block arbitrates interrupts for a small 8-bit core. It keeps ten vector slots: start-up, a software trap, two external port groups, three motor-control event groups, a serial-peripheral event and two timers. Each request is held pending until it is serviced. A per-source enable and a global mask bit (the I bit, kept inside the block) decide whether a pending request may be taken.

When the core reports an instruction boundary, the highest-priority eligible request is granted. In the following cycle the block raises a one-cycle take pulse together with the vector address to fetch from, and the mask bit is set. The core clears the mask with a return-from-interrupt pulse or an unmask pulse. Entering the wait or halt low-power state clears the mask. While the core is asleep, the block raises a wake signal when a request that can end that state is pending.

Each port group combines its enabled pins with an AND, and then runs one edge detector on the result. Peripheral requests are level flags that belong to the peripherals.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the mask bit is 1 and take and wake are low. The first instruction boundary grants the start-up slot with vector FFFEh, regardless of the mask.
- R2: A maskable slot is taken only when the mask bit is 0 and its enable bit is 1. src_en bit k enables slot k+2, with bit 0 for port A, bit 1 for port B, bits 2 to 4 for the motor groups, bit 5 for serial and bits 6 and 7 for timers A and B. Otherwise the request stays pending and is taken at a later boundary once both conditions hold.
- R3: Every grant sets the mask bit. A return-from-interrupt pulse or an unmask pulse clears it, and a mask pulse sets it.
- R4: A trap pulse is latched and granted with vector FFFCh, whatever the mask bit and the enables.
- R5: Slot s has vector FFFEh minus 2·s. Slot order: 0 start-up, 1 trap, 2 port A, 3 port B, 4 to 6 motor groups, 7 serial, 8 timer A, 9 timer B. Peripheral flag bit k drives slot 4+k. When several slots are eligible, the one with the highest vector address wins.
- R6: A port group latches an edge of its combined level. A rise is detected when its rise-select input is 1, and a fall when it is 0. The latch clears when that slot is granted.
- R7: The combined level of a port group is the AND of its enabled pins, and pins whose enable is 0 have no effect. A low enabled pin therefore blocks a rising edge on another enabled pin.
- R8: A peripheral request exists only while its flag is high. If the flag drops before the request is granted, the request is lost.
- R9: Arbitration happens only in a cycle with the boundary input high. The take pulse and vector appear in the next cycle and last one cycle.
- R10: A wait-entry or halt-entry pulse clears the mask bit unless a grant happens in the same cycle.
- R11: In the wait state, any enabled pending maskable request raises wake. In the halt state, only an enabled pending port group does. Wake returns the state to running on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Core is at an instruction boundary |
| trap_req | input | 1 | Software trap executed (pulse) |
| iret | input | 1 | Return from interrupt (clears mask) |
| mask_set | input | 1 | Software sets the mask bit |
| mask_clr | input | 1 | Software clears the mask bit |
| enter_wait | input | 1 | Core enters the wait state (pulse) |
| enter_halt | input | 1 | Core enters the halt state (pulse) |
| src_en | input | 8 | Per-slot enables for slots 2 to 9 |
| pa_pins | input | PA_W | Port A pin levels |
| pa_pin_en | input | PA_W | Port A pins that take part in the interrupt |
| pa_rise | input | 1 | Port A: 1 rising edge, 0 falling edge |
| pb_pins | input | PB_W | Port B pin levels |
| pb_pin_en | input | PB_W | Port B pins that take part in the interrupt |
| pb_rise | input | 1 | Port B: 1 rising edge, 0 falling edge |
| per_flag | input | N_PER | Peripheral request flags |
| take_o | output | 1 | Interrupt granted (one cycle) |
| vector_o | output | 16 | Vector address of the granted slot |
| i_bit_o | output | 1 | Current global mask bit |
| wake_o | output | 1 | Wake request from wait or halt |

## Verification
The bench uses the default build: eight port A pins, six port B pins and six peripheral flags, which fills all ten slots and the full 8-bit enable field. With that build every priority pair and every vector from FFECh to FFFEh can be reached. The combining of several port A pins can be tested with one pin holding the group low. Random flag and enable mixes under both mask states exercise the priority order. Directed sequences cover trap against mask, lost flags, and halt-state wake filtering.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    LP_RUN  = 2'd0,
    LP_WAIT = 2'd1,
    LP_HALT = 2'd2
  } lp_state_e;

  // vector address of a slot: top address minus two bytes per slot
  function automatic logic [15:0] slot_vector(input logic [15:0] top, input int unsigned slot);
    return top - 16'(slot * 2);
  endfunction

endpackage

// File: rtl/irq_edge_group.sv
module irq_edge_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] pin_en,
  input  logic         rise_sel,
  input  logic         clr,
  output logic         pend_o
);

  logic combined;
  logic prev_q;
  logic primed_q;
  logic pend_q;
  logic edge_hit;

  // pins left out of the group read as 1 so they never pull the AND low
  assign combined = &(pins | ~pin_en);
  assign edge_hit = primed_q && (rise_sel ? (combined && !prev_q) : (!combined && prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      primed_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      prev_q   <= combined;
      primed_q <= 1'b1;
      if (edge_hit)  pend_q <= 1'b1;
      else if (clr)  pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  p_edge_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> pend_q);

  p_grant_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !pend_q);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  // lowest slot index carries the highest vector address and wins
  always_comb begin
    grant = '0;
    for (int s = N - 1; s >= 0; s--) begin
      if (req[s]) grant = '0;
      if (req[s]) grant[s] = 1'b1;
    end
  end

  assign any = |req;

  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));

  p_grant_is_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int          PA_W    = 8,
  parameter int          PB_W    = 6,
  parameter int          N_PER   = 6,
  parameter logic [15:0] TOP_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              trap_req,
  input  logic              iret,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              enter_wait,
  input  logic              enter_halt,
  input  logic [N_PER+1:0]  src_en,
  input  logic [PA_W-1:0]   pa_pins,
  input  logic [PA_W-1:0]   pa_pin_en,
  input  logic              pa_rise,
  input  logic [PB_W-1:0]   pb_pins,
  input  logic [PB_W-1:0]   pb_pin_en,
  input  logic              pb_rise,
  input  logic [N_PER-1:0]  per_flag,
  output logic              take_o,
  output logic [15:0]       vector_o,
  output logic              i_bit_o,
  output logic              wake_o
);

  localparam int N_EXT  = 2;
  localparam int N_EN   = N_EXT + N_PER;
  localparam int N_SLOT = 2 + N_EN;
  localparam int S_PA   = 2;
  localparam int S_PB   = 3;

  logic              boot_q, trap_q, i_q, take_q;
  logic [15:0]       vec_q;
  lp_state_e         lp_q;
  logic              pa_pend, pb_pend;
  logic [N_SLOT-1:0] pend, elig, grant;
  logic              any_elig, fire;
  logic              maskable_ready, ext_ready, wake;
  logic [15:0]       grant_vec;

  assign pend = {per_flag, pb_pend, pa_pend, trap_q, boot_q};

  // start-up and trap ignore the mask; the rest need enable and I == 0
  assign elig[0] = pend[0];
  assign elig[1] = pend[1];
  for (genvar g = 2; g < N_SLOT; g++) begin : g_elig
    assign elig[g] = pend[g] && src_en[g-2] && !i_q;
  end

  irq_edge_group #(.W(PA_W)) i_port_a (
    .clk(clk), .rst_n(rst_n), .pins(pa_pins), .pin_en(pa_pin_en),
    .rise_sel(pa_rise), .clr(fire && grant[S_PA]), .pend_o(pa_pend));

  irq_edge_group #(.W(PB_W)) i_port_b (
    .clk(clk), .rst_n(rst_n), .pins(pb_pins), .pin_en(pb_pin_en),
    .rise_sel(pb_rise), .clr(fire && grant[S_PB]), .pend_o(pb_pend));

  irq_arbiter #(.N(N_SLOT)) i_arb (
    .clk(clk), .rst_n(rst_n), .req(elig), .grant(grant), .any(any_elig));

  assign fire = boundary && any_elig;

  always_comb begin
    grant_vec = TOP_VEC;
    for (int s = 0; s < N_SLOT; s++) begin
      if (grant[s]) grant_vec = slot_vector(TOP_VEC, s);
    end
  end

  assign maskable_ready = |(pend[N_SLOT-1:2] & src_en);
  assign ext_ready      = |(pend[S_PB:S_PA] & src_en[1:0]);
  assign wake = ((lp_q == LP_WAIT) && maskable_ready) || ((lp_q == LP_HALT) && ext_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      trap_q <= 1'b0;
      i_q    <= 1'b1;
      take_q <= 1'b0;
      vec_q  <= '0;
      lp_q   <= LP_RUN;
    end else begin
      take_q <= fire;
      if (fire) vec_q <= grant_vec;
      if (fire && grant[0]) boot_q <= 1'b0;
      if (trap_req)                trap_q <= 1'b1;
      else if (fire && grant[1])   trap_q <= 1'b0;
      if (fire)                              i_q <= 1'b1;
      else if (enter_wait || enter_halt)     i_q <= 1'b0;
      else if (iret || mask_clr)             i_q <= 1'b0;
      else if (mask_set)                     i_q <= 1'b1;
      if (wake)            lp_q <= LP_RUN;
      else if (enter_halt) lp_q <= LP_HALT;
      else if (enter_wait) lp_q <= LP_WAIT;
    end
  end

  assign take_o   = take_q;
  assign vector_o = vec_q;
  assign i_bit_o  = i_q;
  assign wake_o   = wake;

  p_grant_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> i_q);

  p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && i_q && !pend[0] && !pend[1]) |=> !take_q);

  p_only_on_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> !take_q);

  p_vector_in_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (!vec_q[0] && vec_q <= TOP_VEC && vec_q >= TOP_VEC - 16'(2 * (N_SLOT - 1))));

  p_sleep_unmasks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((enter_wait || enter_halt) && !fire) |=> !i_q);

  p_halt_ext_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_q == LP_HALT) && wake) |-> (pend[S_PA] || pend[S_PB]));

  p_trap_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && trap_q && !boot_q) |=> (take_q && vec_q == TOP_VEC - 16'd2));

endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;

  localparam int PA_W = 8;
  localparam int PB_W = 6;
  localparam int N_PER = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 0, trap_req = 0, iret = 0, mask_set = 0, mask_clr = 0;
  logic enter_wait = 0, enter_halt = 0;
  logic [N_PER+1:0] src_en = '0;
  logic [PA_W-1:0] pa_pins = '0, pa_pin_en = '0;
  logic [PB_W-1:0] pb_pins = '1, pb_pin_en = '0;
  logic pa_rise = 1'b1, pb_rise = 1'b0;
  logic [N_PER-1:0] per_flag = '0;
  logic take_o, i_bit_o, wake_o;
  logic [15:0] vector_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .trap_req(trap_req), .iret(iret),
    .mask_set(mask_set), .mask_clr(mask_clr), .enter_wait(enter_wait), .enter_halt(enter_halt),
    .src_en(src_en), .pa_pins(pa_pins), .pa_pin_en(pa_pin_en), .pa_rise(pa_rise),
    .pb_pins(pb_pins), .pb_pin_en(pb_pin_en), .pb_rise(pb_rise), .per_flag(per_flag),
    .take_o(take_o), .vector_o(vector_o), .i_bit_o(i_bit_o), .wake_o(wake_o));

  // table as the requirement words it: FFFE down in steps of two
  function automatic logic [15:0] expect_vec(input int slot);
    return 16'hFFFE - 16'(slot << 1);
  endfunction

  function automatic int first_slot(input logic [N_PER-1:0] flags, input logic [N_PER-1:0] en);
    for (int k = 0; k < N_PER; k++) if (flags[k] && en[k]) return 4 + k;
    return -1;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // one boundary cycle, then look at the grant
  task automatic grant_check(input string req, input logic exp_take, input logic [15:0] exp_vec);
    boundary = 1; tick(); boundary = 0;
    check(req, {15'd0, take_o}, {15'd0, exp_take});
    if (exp_take) check(req, vector_o, exp_vec);
  endtask

  task automatic pulse_clr();
    mask_clr = 1; tick(); mask_clr = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    rst_n = 1; tick();
    // R1 reset state
    check("R1 mask", {15'd0, i_bit_o}, 16'd1);
    check("R1 take", {15'd0, take_o}, 16'd0);
    check("R1 wake", {15'd0, wake_o}, 16'd0);
    grant_check("R1 startup", 1'b1, 16'hFFFE);
    // R9 nothing pending, and no grant without boundary
    grant_check("R9 idle", 1'b0, 16'h0);
    src_en = '1; per_flag = 6'b100000; tick();
    check("R9 no boundary", {15'd0, take_o}, 16'd0);
    // R2 masked request stays pending
    grant_check("R2 masked", 1'b0, 16'h0);
    pulse_clr();
    check("R3 unmask", {15'd0, i_bit_o}, 16'd0);
    grant_check("R2 later taken", 1'b1, 16'hFFEC);
    check("R3 grant sets mask", {15'd0, i_bit_o}, 16'd1);
    per_flag = '0;
    // R2 enable off
    src_en = 8'b1101_1111; per_flag = 6'b001000; pulse_clr();
    grant_check("R2 disabled", 1'b0, 16'h0);
    src_en = '1;
    grant_check("R2 enabled", 1'b1, 16'hFFF0);
    per_flag = '0;
    // R8 dropped flag is lost
    per_flag = 6'b000001; tick(); per_flag = '0; pulse_clr();
    grant_check("R8 lost", 1'b0, 16'h0);
    // R3 mask set and iret
    mask_set = 1; tick(); mask_set = 0;
    check("R3 mask set", {15'd0, i_bit_o}, 16'd1);
    iret = 1; tick(); iret = 0;
    check("R3 iret", {15'd0, i_bit_o}, 16'd0);
    mask_set = 1; tick(); mask_set = 0;
    // R4 trap under mask and disabled sources
    src_en = '0; trap_req = 1; tick(); trap_req = 0;
    grant_check("R4 trap", 1'b1, 16'hFFFC);
    src_en = '1;
    // R5 trap beats peripherals even unmasked
    per_flag = '1; pulse_clr(); trap_req = 1; tick(); trap_req = 0;
    grant_check("R5 trap first", 1'b1, 16'hFFFC);
    pulse_clr();
    grant_check("R5 motor first", 1'b1, 16'hFFF6);
    per_flag = '0;
    // R6 port A rising edge, cleared on grant
    pa_pin_en = 8'h01; pa_rise = 1; pa_pins = 8'h00; tick(); tick();
    pa_pins = 8'h01; tick(); pulse_clr();
    grant_check("R6 rise A", 1'b1, 16'hFFFA);
    pulse_clr();
    grant_check("R6 cleared", 1'b0, 16'h0);
    // R6 port B falling edge
    pb_pin_en = 6'h01; pb_rise = 0; pb_pins = 6'h3F; tick(); tick();
    pb_pins = 6'h3E; tick();
    grant_check("R6 fall B", 1'b1, 16'hFFF8);
    // R5 both ports: A over B
    pb_pins = 6'h3F; pa_pins = 8'h00; tick(); tick();
    pa_pins = 8'h01; pb_pins = 6'h3E; tick(); pulse_clr();
    grant_check("R5 A over B", 1'b1, 16'hFFFA);
    pulse_clr();
    grant_check("R5 then B", 1'b1, 16'hFFF8);
    // R7 low enabled pin blocks rising edge
    pa_pins = 8'h00; pa_pin_en = 8'h03; tick(); tick();
    pa_pins = 8'h01; tick(); pulse_clr();
    grant_check("R7 blocked", 1'b0, 16'h0);
    pa_pins = 8'h03; tick(); pulse_clr();
    grant_check("R7 combined rise", 1'b1, 16'hFFFA);
    // R7 disabled pin has no effect
    pa_pins = 8'h07; tick(); pa_pins = 8'h03; tick(); pa_pins = 8'h07; tick(); pulse_clr();
    grant_check("R7 ignored pin", 1'b0, 16'h0);
    // R10/R11 wait
    mask_set = 1; tick(); mask_set = 0;
    enter_wait = 1; tick(); enter_wait = 0;
    check("R10 wait unmask", {15'd0, i_bit_o}, 16'd0);
    check("R11 wait idle", {15'd0, wake_o}, 16'd0);
    per_flag = 6'b010000; #1;
    check("R11 wait wake", {15'd0, wake_o}, 16'd1);
    tick(); per_flag = '0; #1;
    check("R11 back to run", {15'd0, wake_o}, 16'd0);
    // R10/R11 halt: peripheral does not wake, port does
    mask_set = 1; tick(); mask_set = 0;
    pa_pins = 8'h00; pa_pin_en = 8'h01; tick();
    enter_halt = 1; tick(); enter_halt = 0;
    check("R10 halt unmask", {15'd0, i_bit_o}, 16'd0);
    per_flag = 6'b010000; #1;
    check("R11 halt ignores peripheral", {15'd0, wake_o}, 16'd0);
    tick(); per_flag = '0;
    pa_pins = 8'h01; tick();
    check("R11 halt port wake", {15'd0, wake_o}, 16'd1);
    grant_check("R6 wake source taken", 1'b1, 16'hFFFA);
    // R5/R2 random mixes
    for (int n = 0; n < 60; n++) begin
      logic [N_PER-1:0] fl;
      logic [N_PER-1:0] en;
      logic m;
      int s;
      fl = N_PER'($urandom); en = N_PER'($urandom); m = 1'($urandom);
      if (m) begin mask_set = 1; tick(); mask_set = 0; end
      else pulse_clr();
      per_flag = fl; src_en = {en, 2'b00};
      s = m ? -1 : first_slot(fl, en);
      grant_check("R5 random", s >= 0, (s >= 0) ? expect_vec(s) : 16'h0);
      per_flag = '0; tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule